// File: doc/BRIEF.md
# Auto-Incrementing Indirect Register Window

This block gives a host a byte-wide window into a disk controller's parameter registers. It does this through two ports. The data port reaches a bank of eleven slots chosen by an internal pointer. The command/status port takes command bytes on writes and returns an interrupt-status byte on reads. Each data-port access moves the pointer one slot forward, so software can load or dump the whole parameter set in one burst of accesses.

The host can reposition the pointer with a set-pointer command byte. A reset command byte clears the pointer and the positioning parameters. Writes and reads at the same pointer value reach different things. Writes load the transfer parameters: DMA address, desired sector, head and cylinder, sector count, retry count, mode, termination control and data. Reads return the DMA address, the desired sector, the current head/cylinder position, chip status, drive status and data. The current position and all status bytes come from outside the block as inputs.

Top module: `dkc_regwin`

## Requirements
- R1: A data-port access (read, write, or both in one cycle) advances the pointer by exactly one when the pointer is below 10. When the pointer is 10 or above, the access leaves it unchanged, so repeated accesses keep reaching slot 10.
- R2: A command-port write of 8'h00 sets the pointer to 0. A command byte whose upper nibble is 4'b0100 loads the pointer from its lower nibble. Any other command byte leaves the pointer and every register unchanged.
- R3: Slots 0, 1 and 2 hold DMA address bits 7:0, 15:8 and 23:16. A write to one of these slots replaces only its own byte, and a read returns that byte.
- R4: Slot 3 is the desired sector register, which can be both written and read.
- R5: A write to slot 4 loads data bits 3:0 into the desired head and data bits 6:4 into desired cylinder bits 10:8. A write to slot 5 loads data bits 7:0 into desired cylinder bits 7:0.
- R6: A read of slot 4 returns {1'b0, current cylinder bits 10:8, current head bits 3:0}. A read of slot 5 returns current cylinder bits 7:0.
- R7: Writes to slots 6 and 7 load the sector count and the retry count. Reads of slots 6 and 7 return 8'h00.
- R8: Writes to slots 8 and 9 load the mode and termination-control registers. Reads of slots 8 and 9 return the chip-status and drive-status inputs.
- R9: Slot 10 is the data register, which can be both written and read.
- R10: The reset command byte (8'h00) clears termination control, desired sector, desired head and desired cylinder. The DMA address, sector count, retry count, mode and data registers keep their values.
- R11: At pointer values 11 to 15, reads return 8'h00 and writes change no register.
- R12: Read data is registered. It appears on rdata in the cycle after rd_en and holds until the next read. A status-port read (port_sel=1) returns the irq_stat input and does not move the pointer.
- R13: Synchronous active-high reset clears the pointer, every register and rdata to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, single cycle |
| rd_en | input | 1 | Read strobe, single cycle |
| port_sel | input | 1 | 0 = data port, 1 = command (write) / status (read) port |
| wdata | input | 8 | Write data or command byte |
| rdata | output | 8 | Registered read data |
| cur_head | input | 4 | Current head of the selected drive |
| cur_cyl | input | 11 | Current cylinder of the selected drive |
| chip_stat | input | 8 | Chip status byte |
| drv_stat | input | 8 | Drive status byte |
| irq_stat | input | 8 | Interrupt status byte |
| reg_ptr | output | 4 | Current register pointer |
| dma_addr | output | 24 | DMA address |
| des_sect | output | 8 | Desired sector |
| des_head | output | 4 | Desired head |
| des_cyl | output | 11 | Desired cylinder |
| sec_cnt | output | 8 | Sector count |
| retry_cnt | output | 8 | Retry count |
| mode_reg | output | 8 | Operating mode |
| term_ctl | output | 8 | Termination control |
| data_reg | output | 8 | Data register |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 24-bit DMA address, a 4-bit head and an 11-bit cylinder. These widths make the cylinder's three high bits share a byte with the head. With a 4-bit pointer, the unused values 11 to 15 can be reached through the set-pointer command, and the bench exercises them. The saturation at slot 10 is reached by a full eleven-write burst followed by extra accesses. The split between the read map and the write map is exposed by reading back every slot after writing it.

// File: rtl/dkc_regwin_pkg.sv
package dkc_regwin_pkg;
  localparam int SLOT_W = 4;
  localparam logic [SLOT_W-1:0] SL_DMA0  = 4'd0;
  localparam logic [SLOT_W-1:0] SL_SECT  = 4'd3;
  localparam logic [SLOT_W-1:0] SL_HEAD  = 4'd4;
  localparam logic [SLOT_W-1:0] SL_CYL   = 4'd5;
  localparam logic [SLOT_W-1:0] SL_SCNT  = 4'd6;
  localparam logic [SLOT_W-1:0] SL_RETRY = 4'd7;
  localparam logic [SLOT_W-1:0] SL_MODE  = 4'd8;
  localparam logic [SLOT_W-1:0] SL_TERM  = 4'd9;
  localparam logic [SLOT_W-1:0] SL_DATA  = 4'd10;
  localparam logic [7:0]        CMD_CLEAR  = 8'h00;
  localparam logic [3:0]        CMD_SETPTR = 4'b0100;
endpackage

// File: rtl/dkc_ptr_ctl.sv
module dkc_ptr_ctl
  import dkc_regwin_pkg::*;
#(
  parameter int PW = SLOT_W,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_acc,
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_byte,
  output logic [PW-1:0] ptr,
  output logic          clr_cmd
);
  localparam logic [PW-1:0] LAST = PW'(SL_DATA);

  logic set_cmd;

  always_comb begin
    clr_cmd = cmd_wr && (cmd_byte == DW'(CMD_CLEAR));
    set_cmd = cmd_wr && (cmd_byte[DW-1 -: 4] == CMD_SETPTR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (clr_cmd) begin
      ptr <= '0;
    end else if (set_cmd) begin
      ptr <= cmd_byte[PW-1:0];
    end else if (data_acc && (ptr < LAST)) begin
      ptr <= ptr + PW'(1);
    end
  end

  p_ptr_step_r1: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !cmd_wr && (ptr < LAST)) |=> (ptr == $past(ptr) + PW'(1)));
  p_ptr_sat_r1: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !cmd_wr && (ptr >= LAST)) |=> $stable(ptr));
  p_ptr_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (cmd_byte == '0)) |=> (ptr == '0));
  p_ptr_load_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (cmd_byte[DW-1 -: 4] == 4'b0100)) |=> (ptr == $past(cmd_byte[PW-1:0])));
endmodule

// File: rtl/dkc_wr_bank.sv
module dkc_wr_bank
  import dkc_regwin_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PW     = SLOT_W,
  parameter int DMA_W  = 24,
  parameter int HEAD_W = 4,
  parameter int CYL_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              clr,
  input  logic [PW-1:0]     ptr,
  input  logic [DW-1:0]     wdata,
  output logic [DMA_W-1:0]  dma_addr,
  output logic [DW-1:0]     des_sect,
  output logic [HEAD_W-1:0] des_head,
  output logic [CYL_W-1:0]  des_cyl,
  output logic [DW-1:0]     sec_cnt,
  output logic [DW-1:0]     retry_cnt,
  output logic [DW-1:0]     mode_reg,
  output logic [DW-1:0]     term_ctl,
  output logic [DW-1:0]     data_reg
);
  localparam int DMA_BYTES = DMA_W / DW;
  localparam int CYL_HI    = CYL_W - DW;

  for (genvar g = 0; g < DMA_BYTES; g++) begin : g_dma
    always_ff @(posedge clk) begin
      if (rst) begin
        dma_addr[g*DW +: DW] <= '0;
      end else if (wr && (ptr == PW'(SL_DMA0) + PW'(g))) begin
        dma_addr[g*DW +: DW] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      des_sect  <= '0;
      des_head  <= '0;
      des_cyl   <= '0;
      term_ctl  <= '0;
    end else if (clr) begin
      des_sect  <= '0;
      des_head  <= '0;
      des_cyl   <= '0;
      term_ctl  <= '0;
    end else if (wr) begin
      case (ptr)
        PW'(SL_SECT): des_sect <= wdata;
        PW'(SL_HEAD): begin
          des_head              <= wdata[HEAD_W-1:0];
          des_cyl[CYL_W-1:DW]   <= wdata[HEAD_W +: CYL_HI];
        end
        PW'(SL_CYL):  des_cyl[DW-1:0] <= wdata;
        PW'(SL_TERM): term_ctl <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_cnt   <= '0;
      retry_cnt <= '0;
      mode_reg  <= '0;
      data_reg  <= '0;
    end else if (wr) begin
      case (ptr)
        PW'(SL_SCNT):  sec_cnt   <= wdata;
        PW'(SL_RETRY): retry_cnt <= wdata;
        PW'(SL_MODE):  mode_reg  <= wdata;
        PW'(SL_DATA):  data_reg  <= wdata;
        default: ;
      endcase
    end
  end

  p_dma_own_byte_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && (ptr == PW'(1))) |=> ($stable(dma_addr[DW-1:0]) && $stable(dma_addr[DMA_W-1 -: DW])));
  p_clear_fields_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> ((term_ctl == '0) && (des_sect == '0) && (des_head == '0) && (des_cyl == '0)));
  p_clear_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> ($stable(mode_reg) && $stable(dma_addr) && $stable(data_reg)));
  p_high_slot_inert_r11: assert property (@(posedge clk) disable iff (rst)
    (wr && !clr && (ptr > PW'(SL_DATA))) |=> ($stable(data_reg) && $stable(term_ctl) && $stable(dma_addr)));
endmodule

// File: rtl/dkc_rd_mux.sv
module dkc_rd_mux
  import dkc_regwin_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PW     = SLOT_W,
  parameter int DMA_W  = 24,
  parameter int HEAD_W = 4,
  parameter int CYL_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_data,
  input  logic              rd_stat,
  input  logic [PW-1:0]     ptr,
  input  logic [DMA_W-1:0]  dma_addr,
  input  logic [DW-1:0]     des_sect,
  input  logic [DW-1:0]     data_reg,
  input  logic [HEAD_W-1:0] cur_head,
  input  logic [CYL_W-1:0]  cur_cyl,
  input  logic [DW-1:0]     chip_stat,
  input  logic [DW-1:0]     drv_stat,
  input  logic [DW-1:0]     irq_stat,
  output logic [DW-1:0]     rdata
);
  localparam int DMA_BYTES = DMA_W / DW;
  localparam int CYL_HI    = CYL_W - DW;
  localparam int PAD_W     = DW - CYL_HI - HEAD_W;

  logic [DW-1:0] slot_val;

  always_comb begin
    slot_val = '0;
    for (int i = 0; i < DMA_BYTES; i++) begin
      if (ptr == PW'(i)) slot_val = dma_addr[i*DW +: DW];
    end
    case (ptr)
      PW'(SL_SECT): slot_val = des_sect;
      PW'(SL_HEAD): slot_val = {{PAD_W{1'b0}}, cur_cyl[CYL_W-1:DW], cur_head};
      PW'(SL_CYL):  slot_val = cur_cyl[DW-1:0];
      PW'(SL_MODE): slot_val = chip_stat;
      PW'(SL_TERM): slot_val = drv_stat;
      PW'(SL_DATA): slot_val = data_reg;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_stat) begin
      rdata <= irq_stat;
    end else if (rd_data) begin
      rdata <= slot_val;
    end
  end

  p_count_slots_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_data && ((ptr == PW'(6)) || (ptr == PW'(7)))) |=> (rdata == '0));
  p_status_slots_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_data && (ptr == PW'(8))) |=> (rdata == $past(chip_stat)));
  p_high_slot_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_data && (ptr > PW'(10))) |=> (rdata == '0));
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!rd_data && !rd_stat) |=> $stable(rdata));
  p_irq_read_r12: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (rdata == $past(irq_stat)));
endmodule

// File: rtl/dkc_regwin.sv
module dkc_regwin
  import dkc_regwin_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PW     = SLOT_W,
  parameter int DMA_W  = 24,
  parameter int HEAD_W = 4,
  parameter int CYL_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              port_sel,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [HEAD_W-1:0] cur_head,
  input  logic [CYL_W-1:0]  cur_cyl,
  input  logic [DW-1:0]     chip_stat,
  input  logic [DW-1:0]     drv_stat,
  input  logic [DW-1:0]     irq_stat,
  output logic [PW-1:0]     reg_ptr,
  output logic [DMA_W-1:0]  dma_addr,
  output logic [DW-1:0]     des_sect,
  output logic [HEAD_W-1:0] des_head,
  output logic [CYL_W-1:0]  des_cyl,
  output logic [DW-1:0]     sec_cnt,
  output logic [DW-1:0]     retry_cnt,
  output logic [DW-1:0]     mode_reg,
  output logic [DW-1:0]     term_ctl,
  output logic [DW-1:0]     data_reg
);
  logic data_wr, data_rd, data_acc, cmd_wr, stat_rd, clr_cmd;

  always_comb begin
    data_wr  = wr_en && !port_sel;
    data_rd  = rd_en && !port_sel;
    data_acc = data_wr || data_rd;
    cmd_wr   = wr_en && port_sel;
    stat_rd  = rd_en && port_sel;
  end

  dkc_ptr_ctl #(.PW(PW), .DW(DW)) u_ptr (
    .clk(clk), .rst(rst), .data_acc(data_acc), .cmd_wr(cmd_wr),
    .cmd_byte(wdata), .ptr(reg_ptr), .clr_cmd(clr_cmd)
  );

  dkc_wr_bank #(.DW(DW), .PW(PW), .DMA_W(DMA_W), .HEAD_W(HEAD_W), .CYL_W(CYL_W)) u_wr (
    .clk(clk), .rst(rst), .wr(data_wr), .clr(clr_cmd), .ptr(reg_ptr), .wdata(wdata),
    .dma_addr(dma_addr), .des_sect(des_sect), .des_head(des_head), .des_cyl(des_cyl),
    .sec_cnt(sec_cnt), .retry_cnt(retry_cnt), .mode_reg(mode_reg),
    .term_ctl(term_ctl), .data_reg(data_reg)
  );

  dkc_rd_mux #(.DW(DW), .PW(PW), .DMA_W(DMA_W), .HEAD_W(HEAD_W), .CYL_W(CYL_W)) u_rd (
    .clk(clk), .rst(rst), .rd_data(data_rd), .rd_stat(stat_rd), .ptr(reg_ptr),
    .dma_addr(dma_addr), .des_sect(des_sect), .data_reg(data_reg),
    .cur_head(cur_head), .cur_cyl(cur_cyl), .chip_stat(chip_stat),
    .drv_stat(drv_stat), .irq_stat(irq_stat), .rdata(rdata)
  );

  p_status_read_keeps_ptr_r12: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !wr_en) |=> $stable(reg_ptr));
  p_other_cmd_inert_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (wdata != '0) && (wdata[DW-1 -: 4] != 4'b0100)) |=> ($stable(reg_ptr) && $stable(term_ctl) && $stable(des_cyl)));
endmodule

// File: tb/sim_dkc_regwin.sv
module sim_dkc_regwin;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  cur_head = '0;
  logic [10:0] cur_cyl = '0;
  logic [7:0]  chip_stat = '0, drv_stat = '0, irq_stat = '0;
  logic [3:0]  reg_ptr;
  logic [23:0] dma_addr;
  logic [7:0]  des_sect, sec_cnt, retry_cnt, mode_reg, term_ctl, data_reg;
  logic [3:0]  des_head;
  logic [10:0] des_cyl;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  dkc_regwin u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
    .wdata(wdata), .rdata(rdata), .cur_head(cur_head), .cur_cyl(cur_cyl),
    .chip_stat(chip_stat), .drv_stat(drv_stat), .irq_stat(irq_stat),
    .reg_ptr(reg_ptr), .dma_addr(dma_addr), .des_sect(des_sect), .des_head(des_head),
    .des_cyl(des_cyl), .sec_cnt(sec_cnt), .retry_cnt(retry_cnt), .mode_reg(mode_reg),
    .term_ctl(term_ctl), .data_reg(data_reg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    @(negedge clk);
    port_sel = sel; wr_en = 1'b1; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    port_sel = sel; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) pend <= rd_en && !rst;

  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {24'd0, rdata}, {24'd0, e});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 ptr after reset", reg_ptr, 0);
    chk("R13 rdata after reset", rdata, 0);
    chk("R13 regs after reset", {dma_addr, data_reg}, 0);

    // burst over slots 0..10
    wr(0, 8'hA1); wr(0, 8'hB2); wr(0, 8'hC3); wr(0, 8'h05);
    wr(0, 8'h5A); wr(0, 8'h34); wr(0, 8'h07); wr(0, 8'h03);
    wr(0, 8'h81); wr(0, 8'h20); wr(0, 8'hEE);
    chk("R1 ptr saturated at 10", reg_ptr, 10);
    chk("R3 dma bytes", dma_addr, 24'hC3B2A1);
    chk("R4 desired sector", des_sect, 8'h05);
    chk("R5 desired head", des_head, 4'hA);
    chk("R5 desired cylinder", des_cyl, 11'h534);
    chk("R7 sec/retry", {sec_cnt, retry_cnt}, 16'h0703);
    chk("R8 mode/term", {mode_reg, term_ctl}, 16'h8120);
    chk("R9 data write", data_reg, 8'hEE);
    wr(0, 8'h99);
    chk("R1 ptr stays at 10", reg_ptr, 10);
    chk("R9 data rewrite", data_reg, 8'h99);

    wr(1, 8'h41);
    chk("R2 set pointer to 1", reg_ptr, 1);
    wr(0, 8'h77);
    chk("R3 own byte replaced", dma_addr, 24'hC377A1);
    chk("R1 ptr advanced to 2", reg_ptr, 2);
    wr(1, 8'h20);
    chk("R2 other command keeps ptr", reg_ptr, 2);
    chk("R2 other command keeps regs", {term_ctl, des_cyl}, {8'h20, 11'h534});

    cur_head = 4'h3; cur_cyl = 11'h6AB; chip_stat = 8'h44; drv_stat = 8'h92; irq_stat = 8'hA5;
    wr(1, 8'h40);
    rd(0, 8'hA1, "R3 read dma0");
    rd(0, 8'h77, "R3 read dma1");
    rd(0, 8'hC3, "R3 read dma2");
    rd(0, 8'h05, "R4 read sector");
    rd(0, 8'h63, "R6 read head/cyl high");
    rd(0, 8'hAB, "R6 read cyl low");
    rd(0, 8'h00, "R7 read slot6 zero");
    rd(0, 8'h00, "R7 read slot7 zero");
    rd(0, 8'h44, "R8 read chip status");
    rd(0, 8'h92, "R8 read drive status");
    rd(0, 8'h99, "R9 read data");
    rd(0, 8'h99, "R1 repeated read at 10");
    rd(1, 8'hA5, "R12 status port read");
    @(negedge clk);
    chk("R12 status read keeps ptr", reg_ptr, 10);
    repeat (3) @(negedge clk);
    chk("R12 rdata holds", rdata, 8'hA5);

    wr(1, 8'h4C);
    wr(0, 8'h55);
    chk("R11 ptr stays at 12", reg_ptr, 12);
    chk("R11 write ignored", {dma_addr, data_reg, term_ctl, mode_reg}, {24'hC377A1, 8'h99, 8'h20, 8'h81});
    rd(0, 8'h00, "R11 read high slot zero");

    wr(1, 8'h00);
    chk("R2 reset command ptr", reg_ptr, 0);
    chk("R10 cleared fields", {term_ctl, des_sect, des_head, des_cyl}, 0);
    chk("R10 kept fields", {dma_addr, mode_reg, sec_cnt, retry_cnt, data_reg},
        {24'hC377A1, 8'h81, 8'h07, 8'h03, 8'h99});

    repeat (3) @(negedge clk);
    chk("R12 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule